// File: doc/BRIEF.md
# FIFO Flag Offset Programming Unit

This block holds the two threshold offsets that a synchronous FIFO's flag logic uses: the almost-empty offset and the almost-full offset. It drives both values to the flag comparators at all times. It also lets the host change them through either a word-wide parallel port or a one-bit serial port. The storage array and the comparators themselves sit outside this block.

The load method is chosen once, by the level of the `ld` input while the synchronous master reset is held low. High selects serial loading and low selects parallel loading. The same reset also loads a default pair of offsets that belongs to the chosen method. After reset, `ld` acts as the load strobe: write-enabled cycles with `ld` high program the offsets, and read-enabled cycles with `ld` high return them on the readback bus. Readback works only in parallel mode.

In parallel mode an alternating write pointer sends successive words to the almost-empty register and then to the almost-full register. A separate alternating read pointer returns the values in the same order. In serial mode, each strobed write shifts one bit into a chain twice the offset width. The chain takes the almost-empty bits first and the almost-full bits after them, each LSB first. Both offsets change together once the last bit has arrived.

Top module: `fifo_offset_prog`

## Requirements
- R1: A clock edge with `rst_n` low and `ld` high selects serial mode and sets both offsets to `DEF_SER` (0x3FF by default) from the next cycle.
- R2: A clock edge with `rst_n` low and `ld` low selects parallel mode and sets both offsets to `DEF_PAR` (0x07F by default) from the next cycle.
- R3: In parallel mode, each edge with `ld` and `wen` high writes `din` into one offset register. The first write after reset goes to almost-empty, the next to almost-full, and then the pointer returns to almost-empty. The other register holds its value.
- R4: In parallel mode, each edge with `ld` and `ren` high places one offset on `rd_data` from the next cycle. The first read after reset returns almost-empty, the next returns almost-full, and the order then repeats. A write in the same cycle does not affect the value read.
- R5: In serial mode, `rd_data` never changes after reset, whatever the state of `ren`.
- R6: In serial mode, each edge with `ld` and `wen` high shifts `sin` into the chain. Bits 0 to W-1 of the chain are the almost-empty offset and bits W to 2W-1 are the almost-full offset, each taken LSB first. Neither offset changes until the 2W-th bit. From the cycle after that edge, both offsets take the new values together.
- R7: With `ld` low, `wen` and `ren` have no effect: the offsets, `rd_data` and both parallel pointers stay unchanged.
- R8: Master reset clears both parallel pointers and the serial bit count. A partial serial load is discarded.
- R9: The load method changes only at master reset. `din` has no effect in serial mode and `sin` has no effect in parallel mode.
- R10: Master reset clears `rd_data` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| ld | input | 1 | Method select during reset; load strobe afterwards |
| wen | input | 1 | Write enable for offset programming |
| ren | input | 1 | Read enable for offset readback |
| din | input | OFS_W | Parallel offset data in |
| sin | input | 1 | Serial offset data in |
| rd_data | output | OFS_W | Parallel offset readback |
| ae_off | output | OFS_W | Current almost-empty offset |
| af_off | output | OFS_W | Current almost-full offset |

## Verification
The bench builds the block with `OFS_W` = 5, `DEF_SER` = 29 and `DEF_PAR` = 7. These defaults are distinct and fit the narrow word. At this width every one of the 32 offset values can be written into each register in parallel and read back. The serial chain is then only ten bits long, so it can be filled with 32 different offset pairs, and a cut-short chain that is followed by a reset can be driven to the very bit before the commit.

// File: rtl/ofs_prog_pkg.sv
// Shared types for the flag offset programming unit.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package ofs_prog_pkg;

    // Load method latched at master reset.
    typedef enum logic {
        LOAD_PAR = 1'b0,
        LOAD_SER = 1'b1
    } load_mode_e;

    // Which offset register a parallel pointer addresses.
    typedef enum logic {
        SEL_AE = 1'b0,
        SEL_AF = 1'b1
    } ofs_sel_e;

    // Advance an alternating pointer to the other register.
    function automatic ofs_sel_e next_sel(input ofs_sel_e cur);
        return (cur == SEL_AE) ? SEL_AF : SEL_AE;
    endfunction

endpackage

// File: rtl/ofs_par_port.sv
// Parallel access port: alternating write pointer and read pointer,
// plus the registered readback bus.
// Assumes par_en is already qualified by parallel mode and the load strobe.
module ofs_par_port
    import ofs_prog_pkg::*;
#(
    parameter int OFS_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             par_en,
    input  logic             wen,
    input  logic             ren,
    input  logic [OFS_W-1:0] ae_q,
    input  logic [OFS_W-1:0] af_q,
    output logic             we_ae,
    output logic             we_af,
    output ofs_sel_e         wr_sel,
    output ofs_sel_e         rd_sel,
    output logic [OFS_W-1:0] rd_data
);

    logic wr_go;
    logic rd_go;

    // Qualify the strobes once for both pointers.
    always_comb begin
        wr_go = par_en && wen;
        rd_go = par_en && ren;
        we_ae = wr_go && (wr_sel == SEL_AE);
        we_af = wr_go && (wr_sel == SEL_AF);
    end

    // Write pointer: toggles after every parallel write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_sel <= SEL_AE;
        end else if (wr_go) begin
            wr_sel <= next_sel(wr_sel);
        end
    end

    // Read pointer and readback register: capture the addressed offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_sel  <= SEL_AE;
            rd_data <= '0;
        end else if (rd_go) begin
            rd_sel  <= next_sel(rd_sel);
            rd_data <= (rd_sel == SEL_AE) ? ae_q : af_q;
        end
    end

endmodule

// File: rtl/ofs_ser_chain.sv
// Serial load chain: shifts one bit per strobed write into a 2*OFS_W
// shadow register and flags the commit on the final bit.
// Assumes ser_en is already qualified by serial mode, load strobe and wen.
module ofs_ser_chain #(
    parameter int OFS_W = 14,
    localparam int CHAIN_W = 2 * OFS_W,
    localparam int CNT_W = $clog2(CHAIN_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_en,
    input  logic             sin,
    output logic             commit,
    output logic [OFS_W-1:0] ae_new,
    output logic [OFS_W-1:0] af_new,
    output logic [CNT_W-1:0] bit_cnt
);

    logic [CHAIN_W-1:0] shadow;
    logic [CHAIN_W-1:0] shadow_nx;

    // Next chain contents: new bit enters at the top, first bit ends lowest.
    always_comb begin
        shadow_nx = {sin, shadow[CHAIN_W-1:1]};
        commit    = ser_en && (bit_cnt == CNT_W'(CHAIN_W - 1));
        ae_new    = shadow_nx[OFS_W-1:0];
        af_new    = shadow_nx[CHAIN_W-1:OFS_W];
    end

    // Shadow chain and bit counter; counter restarts after each commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow  <= '0;
            bit_cnt <= '0;
        end else if (ser_en) begin
            shadow  <= shadow_nx;
            bit_cnt <= commit ? '0 : bit_cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/fifo_offset_prog.sv
// Flag offset programming unit: latches the load method at master reset,
// holds the almost-empty and almost-full offsets, and routes parallel or
// serial programming into them.
// Assumes a synchronous active-low reset held for at least one clock edge.
module fifo_offset_prog
    import ofs_prog_pkg::*;
#(
    parameter int OFS_W = 14,
    parameter logic [OFS_W-1:0] DEF_SER = OFS_W'(10'h3FF),
    parameter logic [OFS_W-1:0] DEF_PAR = OFS_W'(7'h7F),
    localparam int CNT_W = $clog2(2 * OFS_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic             wen,
    input  logic             ren,
    input  logic [OFS_W-1:0] din,
    input  logic             sin,
    output logic [OFS_W-1:0] rd_data,
    output logic [OFS_W-1:0] ae_off,
    output logic [OFS_W-1:0] af_off
);

    load_mode_e       mode_q;
    logic             ser_mode;
    logic             par_en;
    logic             ser_en;
    logic             we_ae;
    logic             we_af;
    ofs_sel_e         wr_sel;
    ofs_sel_e         rd_sel;
    logic             commit;
    logic [OFS_W-1:0] ae_new;
    logic [OFS_W-1:0] af_new;
    logic [CNT_W-1:0] bit_cnt;

    // Route the strobes to the path of the latched method.
    always_comb begin
        ser_mode = (mode_q == LOAD_SER);
        par_en   = !ser_mode && ld;
        ser_en   = ser_mode && ld && wen;
    end

    // Method latch and offset registers with method-specific defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= ld ? LOAD_SER : LOAD_PAR;
            ae_off <= ld ? DEF_SER : DEF_PAR;
            af_off <= ld ? DEF_SER : DEF_PAR;
        end else if (commit) begin
            ae_off <= ae_new;
            af_off <= af_new;
        end else begin
            if (we_ae) ae_off <= din;
            if (we_af) af_off <= din;
        end
    end

    ofs_par_port #(.OFS_W(OFS_W)) u_par (
        .clk     (clk),
        .rst_n   (rst_n),
        .par_en  (par_en),
        .wen     (wen),
        .ren     (ren),
        .ae_q    (ae_off),
        .af_q    (af_off),
        .we_ae   (we_ae),
        .we_af   (we_af),
        .wr_sel  (wr_sel),
        .rd_sel  (rd_sel),
        .rd_data (rd_data)
    );

    ofs_ser_chain #(.OFS_W(OFS_W)) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .ser_en  (ser_en),
        .sin     (sin),
        .commit  (commit),
        .ae_new  (ae_new),
        .af_new  (af_new),
        .bit_cnt (bit_cnt)
    );

endmodule

// File: rtl/ofs_prog_checker.sv
// Property checker for fifo_offset_prog, attached with bind below.
// Assumes the same parameters as the instance it is bound to.
module ofs_prog_checker #(
    parameter int OFS_W = 14,
    parameter logic [OFS_W-1:0] DEF_SER = OFS_W'(10'h3FF),
    parameter logic [OFS_W-1:0] DEF_PAR = OFS_W'(7'h7F),
    localparam int CNT_W = $clog2(2 * OFS_W)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ld,
    input logic             wen,
    input logic             ren,
    input logic [OFS_W-1:0] din,
    input logic             ser_mode,
    input logic             wr_sel,
    input logic             rd_sel,
    input logic [CNT_W-1:0] bit_cnt,
    input logic [OFS_W-1:0] rd_data,
    input logic [OFS_W-1:0] ae_off,
    input logic [OFS_W-1:0] af_off
);

    // R1 R2 R10: defaults, method and cleared readback after master reset
    assert_reset_defaults_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (ae_off == ($past(ld) ? DEF_SER : DEF_PAR))
                       && (af_off == ($past(ld) ? DEF_SER : DEF_PAR))
                       && (ser_mode == $past(ld)) && (rd_data == '0));

    // R3: a parallel write to almost-empty leaves almost-full alone
    assert_par_write_ae_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_mode && ld && wen && !wr_sel) |=> (ae_off == $past(din)) && $stable(af_off));

    // R3: a parallel write to almost-full leaves almost-empty alone
    assert_par_write_af_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_mode && ld && wen && wr_sel) |=> (af_off == $past(din)) && $stable(ae_off));

    // R4: readback returns the offset the read pointer addressed
    assert_par_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_mode && ld && ren) |=>
            (rd_data == ($past(rd_sel) ? $past(af_off) : $past(ae_off))));

    // R5: readback bus frozen in serial mode
    assert_ser_no_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ser_mode |=> $stable(rd_data));

    // R6: serial offsets move only on a strobed write
    assert_ser_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_mode && !(ld && wen)) |=> $stable(ae_off) && $stable(af_off));

    // R7: no strobe, no change
    assert_no_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(ae_off) && $stable(af_off) && $stable(rd_data)
             && $stable(wr_sel) && $stable(rd_sel));

    // R8: pointers and bit count cleared by master reset
    assert_reset_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (bit_cnt == '0) && !wr_sel && !rd_sel);

    // R6: bit count stays inside the chain length
    assert_cnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(2 * OFS_W - 1));

    // R9: method held between resets
    assert_mode_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(ser_mode));

    // R9: parallel pointers idle in serial mode
    assert_ser_ptr_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ser_mode |=> $stable(wr_sel) && $stable(rd_sel));

    // R9: serial chain idle in parallel mode
    assert_par_cnt_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_mode |=> $stable(bit_cnt));

    // ren is observed only through the read properties above
    logic unused_ren;
    assign unused_ren = ren;

endmodule

bind fifo_offset_prog ofs_prog_checker #(
    .OFS_W   (OFS_W),
    .DEF_SER (DEF_SER),
    .DEF_PAR (DEF_PAR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld       (ld),
    .wen      (wen),
    .ren      (ren),
    .din      (din),
    .ser_mode (ser_mode),
    .wr_sel   (wr_sel),
    .rd_sel   (rd_sel),
    .bit_cnt  (bit_cnt),
    .rd_data  (rd_data),
    .ae_off   (ae_off),
    .af_off   (af_off)
);

// File: tb/fifo_offset_prog_test.sv
`timescale 1ns/100ps
module fifo_offset_prog_test;

    localparam int W = 5;
    localparam logic [W-1:0] DS = 5'd29;
    localparam logic [W-1:0] DP = 5'd7;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ld = 1'b0;
    logic         wen = 1'b0;
    logic         ren = 1'b0;
    logic [W-1:0] din = '0;
    logic         sin = 1'b0;
    logic [W-1:0] rd_data;
    logic [W-1:0] ae_off;
    logic [W-1:0] af_off;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    fifo_offset_prog #(.OFS_W(W), .DEF_SER(DS), .DEF_PAR(DP)) uut (
        .clk(clk), .rst_n(rst_n), .ld(ld), .wen(wen), .ren(ren),
        .din(din), .sin(sin), .rd_data(rd_data), .ae_off(ae_off), .af_off(af_off)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    // One clock: drive at negedge, sample at the next negedge.
    task automatic cyc(input logic l, input logic w, input logic r,
                       input logic [W-1:0] d, input logic s);
        ld = l; wen = w; ren = r; din = d; sin = s;
        @(negedge clk);
        ld = 1'b0; wen = 1'b0; ren = 1'b0;
    endtask

    task automatic do_reset(input logic mode);
        rst_n = 1'b0; ld = mode; wen = 1'b0; ren = 1'b0;
        @(negedge clk);
        rst_n = 1'b1; ld = 1'b0;
    endtask

    // Shift a full serial pair, checking the offsets hold until the last bit.
    task automatic ser_pair(input logic [W-1:0] a, input logic [W-1:0] b,
                            input logic [W-1:0] old_a, input logic [W-1:0] old_b);
        for (int i = 0; i < 2 * W; i++) begin
            logic bitv;
            bitv = (i < W) ? a[i] : b[i - W];
            cyc(1'b1, 1'b1, 1'b0, ~a, bitv);
            if (i == 2 * W - 2) begin
                chk("R6 ae hold before last bit", ae_off, old_a);
                chk("R6 af hold before last bit", af_off, old_b);
            end
        end
        chk("R6 R9 serial ae commit", ae_off, a);
        chk("R6 R9 serial af commit", af_off, b);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1 R10: serial defaults
        do_reset(1'b1);
        chk("R1 ae default", ae_off, DS);
        chk("R1 af default", af_off, DS);
        chk("R10 rd_data reset", rd_data, 0);

        // R2: parallel defaults
        do_reset(1'b0);
        chk("R2 ae default", ae_off, DP);
        chk("R2 af default", af_off, DP);

        // R3 R4: exhaustive parallel writes and readback
        for (int v = 0; v < 32; v++) begin
            logic [W-1:0] a, b, pa, pb;
            a = W'(v); b = W'(31 - v); pa = ae_off; pb = af_off;
            cyc(1'b1, 1'b1, 1'b0, a, ~sin);
            chk("R3 first write to ae", ae_off, a);
            chk("R3 af untouched", af_off, pb);
            cyc(1'b1, 1'b1, 1'b0, b, 1'b1);
            chk("R3 second write to af", af_off, b);
            chk("R3 ae untouched", ae_off, a);
            cyc(1'b1, 1'b0, 1'b1, '0, 1'b0);
            chk("R4 read ae", rd_data, a);
            cyc(1'b1, 1'b0, 1'b1, '0, 1'b0);
            chk("R4 read af", rd_data, b);
            if (pa == pb) n_chk = n_chk + 0;
        end

        // R4: read alongside a write returns the older value
        cyc(1'b1, 1'b1, 1'b1, 5'd3, 1'b0);
        chk("R4 read before same-cycle write", rd_data, 31);
        chk("R3 write with read lands in ae", ae_off, 3);
        cyc(1'b1, 1'b0, 1'b1, '0, 1'b0);
        chk("R4 read af after mixed cycle", rd_data, 0);
        cyc(1'b1, 1'b1, 1'b0, 5'd0, 1'b0);
        chk("R3 pointer wrapped to af", af_off, 0);

        // R7: strobes without ld
        for (int k = 0; k < 4; k++) cyc(1'b0, 1'b1, 1'b1, 5'd21, 1'b1);
        chk("R7 ae unchanged", ae_off, 3);
        chk("R7 af unchanged", af_off, 0);
        chk("R7 rd_data unchanged", rd_data, 0);
        cyc(1'b1, 1'b1, 1'b0, 5'd9, 1'b0);
        chk("R7 write pointer unmoved", ae_off, 9);
        cyc(1'b1, 1'b0, 1'b1, '0, 1'b0);
        chk("R7 read pointer unmoved", rd_data, 9);

        // R8: parallel pointer cleared by reset after one write
        do_reset(1'b0);
        cyc(1'b1, 1'b1, 1'b0, 5'd12, 1'b0);
        cyc(1'b1, 1'b0, 1'b1, '0, 1'b0);
        do_reset(1'b0);
        cyc(1'b1, 1'b1, 1'b0, 5'd17, 1'b0);
        chk("R8 write pointer reset to ae", ae_off, 17);
        chk("R8 af keeps default", af_off, DP);
        cyc(1'b1, 1'b0, 1'b1, '0, 1'b0);
        chk("R8 read pointer reset to ae", rd_data, 17);

        // R6 R9: serial sweep with misleading din
        do_reset(1'b1);
        begin
            logic [W-1:0] oa, ob;
            oa = DS; ob = DS;
            for (int v = 0; v < 32; v++) begin
                logic [W-1:0] a, b;
                a = W'(v); b = W'((v * 7 + 3) % 32);
                ser_pair(a, b, oa, ob);
                oa = a; ob = b;
                // R5: readback ignored in serial mode
                cyc(1'b1, 1'b0, 1'b1, '0, 1'b0);
                chk("R5 rd_data frozen", rd_data, 0);
                chk("R5 ae unaffected by read", ae_off, a);
            end
        end

        // R8: partial chain discarded by reset
        for (int i = 0; i < 2 * W - 1; i++) cyc(1'b1, 1'b1, 1'b0, '0, 1'b1);
        do_reset(1'b1);
        chk("R8 ae default after partial", ae_off, DS);
        chk("R8 af default after partial", af_off, DS);
        ser_pair(5'd5, 5'd26, DS, DS);

        // R9: serial mode ignores parallel data, parallel mode ignores sin
        do_reset(1'b0);
        cyc(1'b1, 1'b1, 1'b0, 5'd2, 1'b1);
        chk("R9 parallel ignores sin", ae_off, 2);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule